// File: doc/BRIEF.md
# Nine-bit FIFO with Read Rewind and Occupancy Flags

This block is a single-clock first-in/first-out buffer for 9-bit words, with a parameterized depth of 1024, 2048 or 4096 entries. No address is ever presented. A write pointer and a read pointer each step forward by one location for every accepted transfer, and the number of stored words is their difference. The write strobe, the read strobe, the clear command and the rewind command are all active-low levels that the block samples on the rising clock edge.

Four active-low status flags are decoded from the occupancy: empty, full, more-than-half-full, and one combined "near an end" flag. The near-an-end flag is asserted within one eighth of either end of the buffer. A rewind command moves the read pointer back to location zero, so that all data written since the last clear can be read a second time. An output-enable input gates a data-valid qualifier. This qualifier stands in for a high-impedance data bus. Read data is registered and comes out in the cycle after the read is accepted.

Top module: `fifo_rt9`

## Requirements
- R1: A clock edge with `clr_n` low while both `wr_n` and `rd_n` are high empties the buffer. After that edge `empty_n`=0, `full_n`=1, `half_n`=1, `near_n`=0 and `q_vld`=0.
- R2: Words leave the buffer in exactly the order in which they were accepted.
- R3: While `full_n` is 0, a low `wr_n` is not accepted. The occupancy and the stored contents do not change.
- R4: While `empty_n` is 0, a low `rd_n` is not accepted. The occupancy stays zero and `q_vld` stays 0 in the following cycle.
- R5: `empty_n` is 0 exactly when the occupancy is 0. `full_n` is 0 exactly when the occupancy equals DEPTH.
- R6: `half_n` is 0 exactly when the occupancy is greater than DEPTH/2. For DEPTH 1024 this means 513 words or more.
- R7: `near_n` is 0 exactly when the occupancy is below DEPTH/8 or above DEPTH-DEPTH/8. For DEPTH 1024 these ranges are 0..127 and 897..1024.
- R8: `q_vld` is 1 in the cycle after an accepted read if `oe_n` is 0 in that cycle. At all other times it is 0, and a high `oe_n` always forces it to 0.
- R9: A read accepted while `oe_n` is high still removes its word from the buffer.
- R10: A clock edge with `rt_n` low, `clr_n` high and both strobes high sets the read pointer to location zero and leaves the write pointer unchanged. The occupancy becomes the number of words written since the last clear, provided that number is at most DEPTH. Reads then restart with the first word written after the clear.
- R11: `clr_n` and `rt_n` are ignored on any edge where `wr_n` or `rd_n` is low. The strobes act normally on such an edge.
- R12: When a read and a write are both requested on the same edge, the result depends on the occupancy. With the buffer neither empty nor full, both are accepted and the occupancy does not change. With the buffer empty, only the write is accepted. With the buffer full, only the read is accepted.
- R13: A word written into an empty buffer can be read on the very next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| clr_n | input | 1 | Clear command, active low, obeyed only with both strobes high |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| rt_n | input | 1 | Rewind command, active low, obeyed only with both strobes high |
| oe_n | input | 1 | Output enable, active low, gates `q_vld` |
| d | input | 9 | Write data |
| q | output | 9 | Registered read data |
| q_vld | output | 1 | Read data valid (replaces a high-impedance state) |
| empty_n | output | 1 | Low when no word is stored |
| full_n | output | 1 | Low when DEPTH words are stored |
| half_n | output | 1 | Low when more than DEPTH/2 words are stored |
| near_n | output | 1 | Low within DEPTH/8 of empty or of full |

## Verification
A read and a write can fall in the same cycle, and the interesting cases are at the ends of the buffer and away from them. The bench requests both strobes together in three situations: at zero occupancy, where only the write may land; at occupancy 128, which sits on the lower near-an-end boundary; and at full, where only the read may land. Each outcome is judged against an arithmetic model of the two pointers. The flags must match the model's occupancy after every edge, and each returned word must match the model's stored word. A further check covers the case where the clear or rewind command coincides with an active strobe. Here the bench confirms through later reads and the flags that the command changed nothing.

// File: rtl/fifo_rt9_pkg.sv
package fifo_rt9_pkg;
  typedef struct packed {
    logic empty_n;
    logic full_n;
    logic half_n;
    logic near_n;
  } fifo_flags_t;
endpackage

// File: rtl/fifo_rt9_ptr.sv
// Pointer control: acceptance of strobes, clear and rewind commands.
module fifo_rt9_ptr #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              clr_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic              rt_n,
  input  logic              empty_n,
  input  logic              full_n,
  output logic              wr_acc,
  output logic              rd_acc,
  output logic [ADDR_W:0]   wr_ptr,
  output logic [ADDR_W:0]   rd_ptr,
  output logic [ADDR_W:0]   level
);
  logic            idle;
  logic            do_clr;
  logic            do_rt;
  logic            wr_en;
  logic            rd_en;
  logic [ADDR_W:0] wr_nx;
  logic [ADDR_W:0] rd_nx;

  always_comb begin
    idle   = wr_n & rd_n;
    do_clr = idle & ~clr_n;
    do_rt  = idle & clr_n & ~rt_n;
    wr_acc = ~wr_n & full_n;
    rd_acc = ~rd_n & empty_n;
    wr_en  = do_clr | wr_acc;
    rd_en  = do_clr | do_rt | rd_acc;
    wr_nx  = do_clr ? '0 : wr_ptr + 1'b1;
    rd_nx  = (do_clr | do_rt) ? '0 : rd_ptr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) wr_ptr <= wr_nx;
    if (rd_en) rd_ptr <= rd_nx;
  end

  // The extra pointer bit keeps full and empty apart.
  assign level = wr_ptr - rd_ptr;
endmodule

// File: rtl/fifo_rt9_store.sv
// Word storage with a registered read port.
module fifo_rt9_store #(
  parameter int WIDTH  = 9,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              wr_acc,
  input  logic              rd_acc,
  input  logic [ADDR_W-1:0] wr_idx,
  input  logic [ADDR_W-1:0] rd_idx,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  rdata,
  output logic              rd_done
);
  localparam int ENTRIES = 1 << ADDR_W;

  logic [WIDTH-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (wr_acc) mem[wr_idx] <= wdata;
    if (rd_acc) rdata <= mem[rd_idx];
    rd_done <= rd_acc;
  end
endmodule

// File: rtl/fifo_rt9_flags.sv
// Occupancy to active-low flag decode.
module fifo_rt9_flags
  import fifo_rt9_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = 10
) (
  input  logic [ADDR_W:0] level,
  output fifo_flags_t     flags
);
  localparam int CW = ADDR_W + 1;
  localparam logic [CW-1:0] K_FULL = CW'(DEPTH);
  localparam logic [CW-1:0] K_HALF = CW'(DEPTH / 2);
  localparam logic [CW-1:0] K_LOW  = CW'(DEPTH / 8);
  localparam logic [CW-1:0] K_HIGH = CW'(DEPTH - DEPTH / 8);

  always_comb begin
    flags.empty_n = (level != '0);
    flags.full_n  = (level != K_FULL);
    flags.half_n  = ~(level > K_HALF);
    flags.near_n  = ~((level < K_LOW) | (level > K_HIGH));
  end
endmodule

// File: rtl/fifo_rt9.sv
module fifo_rt9
  import fifo_rt9_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             wr_n,
  input  logic             rd_n,
  input  logic             rt_n,
  input  logic             oe_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic             q_vld,
  output logic             empty_n,
  output logic             full_n,
  output logic             half_n,
  output logic             near_n
);
  localparam int ADDR_W = $clog2(DEPTH);

  logic            wr_acc;
  logic            rd_acc;
  logic            rd_done;
  logic [ADDR_W:0] wr_ptr;
  logic [ADDR_W:0] rd_ptr;
  logic [ADDR_W:0] level;
  fifo_flags_t     flags;

  fifo_rt9_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk     (clk),
    .clr_n   (clr_n),
    .wr_n    (wr_n),
    .rd_n    (rd_n),
    .rt_n    (rt_n),
    .empty_n (flags.empty_n),
    .full_n  (flags.full_n),
    .wr_acc  (wr_acc),
    .rd_acc  (rd_acc),
    .wr_ptr  (wr_ptr),
    .rd_ptr  (rd_ptr),
    .level   (level)
  );

  fifo_rt9_store #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_store (
    .clk     (clk),
    .wr_acc  (wr_acc),
    .rd_acc  (rd_acc),
    .wr_idx  (wr_ptr[ADDR_W-1:0]),
    .rd_idx  (rd_ptr[ADDR_W-1:0]),
    .wdata   (d),
    .rdata   (q),
    .rd_done (rd_done)
  );

  fifo_rt9_flags #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_flags (
    .level (level),
    .flags (flags)
  );

  assign q_vld   = rd_done & ~oe_n;
  assign empty_n = flags.empty_n;
  assign full_n  = flags.full_n;
  assign half_n  = flags.half_n;
  assign near_n  = flags.near_n;
endmodule

// File: rtl/fifo_rt9_chk.sv
module fifo_rt9_chk (
  input logic clk,
  input logic clr_n,
  input logic wr_n,
  input logic rd_n,
  input logic rt_n,
  input logic oe_n,
  input logic q_vld,
  input logic empty_n,
  input logic full_n,
  input logic half_n,
  input logic near_n
);
  p_reset_clear_r1: assert property (@(posedge clk)
    (!clr_n && wr_n && rd_n) |=> (!empty_n && full_n && half_n && !near_n && !q_vld));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!clr_n)
    (!full_n && !wr_n && rd_n) |=> !full_n);

  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!clr_n)
    (!empty_n && !rd_n && wr_n) |=> (!empty_n && !q_vld));

  p_full_flags_r5: assert property (@(posedge clk) disable iff (!clr_n)
    !full_n |-> (empty_n && !half_n && !near_n));

  p_oe_gate_r8: assert property (@(posedge clk) disable iff (!clr_n)
    oe_n |-> !q_vld);

  p_rdwr_level_r12: assert property (@(posedge clk) disable iff (!clr_n)
    (empty_n && full_n && !wr_n && !rd_n) |=> $stable({empty_n, full_n, half_n, near_n}));
endmodule

bind fifo_rt9 fifo_rt9_chk u_chk (.*);

// File: tb/fifo_rt9_bench.sv
`timescale 1ns/1ps
module fifo_rt9_bench;
  localparam int D = 1024;

  logic       clk = 1'b0;
  logic       clr_n, wr_n, rd_n, rt_n, oe_n;
  logic [8:0] d;
  logic [8:0] q;
  logic       q_vld, empty_n, full_n, half_n, near_n;

  int n_chk = 0;
  int n_fail = 0;
  logic [8:0] mm [D];
  int m_w = 0;
  int m_r = 0;

  always #2 clk = ~clk;

  fifo_rt9 u_fifo_rt9 (
    .clk(clk), .clr_n(clr_n), .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n),
    .oe_n(oe_n), .d(d), .q(q), .q_vld(q_vld), .empty_n(empty_n),
    .full_n(full_n), .half_n(half_n), .near_n(near_n)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [8:0] pat(input int i);
    return 9'((i * 37 + 5) ^ (i >> 2));
  endfunction

  // One clock: drive at the falling edge, update the model, sample 1 ns after the rising edge.
  task automatic cyc(input logic w, input logic r, input logic rt, input logic rs,
                     input logic oe, input logic [8:0] dv, input string tag);
    int cnt;
    logic aw, ar;
    logic [8:0] ed;
    @(negedge clk);
    wr_n = w; rd_n = r; rt_n = rt; clr_n = rs; oe_n = oe; d = dv;
    cnt = m_w - m_r;
    aw = !w && (cnt != D);
    ar = !r && (cnt != 0);
    ed = '0;
    if (w && r && !rs) begin
      m_w = 0; m_r = 0;
    end else if (w && r && !rt) begin
      m_r = 0;
    end else begin
      if (ar) begin ed = mm[m_r % D]; m_r++; end
      if (aw) begin mm[m_w % D] = dv; m_w++; end
    end
    @(posedge clk);
    #1;
    cnt = m_w - m_r;
    check({tag, "/R5 empty_n"}, 32'(empty_n), 32'(cnt != 0));
    check({tag, "/R5 full_n"},  32'(full_n),  32'(cnt != D));
    check({tag, "/R6 half_n"},  32'(half_n),  32'(!(cnt > D / 2)));
    check({tag, "/R7 near_n"},  32'(near_n),  32'(!(cnt < D / 8 || cnt > D - D / 8)));
    check({tag, "/R8 q_vld"},   32'(q_vld),   32'(ar && !oe));
    if (ar && !oe) check({tag, " q data"}, 32'(q), 32'(ed));
  endtask

  task automatic do_clear(input string tag);
    cyc(1, 1, 1, 0, 0, '0, tag);
  endtask

  initial begin
    clr_n = 1'b0; wr_n = 1'b1; rd_n = 1'b1; rt_n = 1'b1; oe_n = 1'b0; d = '0;
    do_clear("R1");
    do_clear("R1");
    check("R1 empty_n", 32'(empty_n), 0);
    check("R1 full_n",  32'(full_n), 1);
    check("R1 half_n",  32'(half_n), 1);
    check("R1 near_n",  32'(near_n), 0);
    check("R1 q_vld",   32'(q_vld), 0);

    // Full sweep of every occupancy on the way up and down.
    for (int i = 0; i < D; i++) cyc(0, 1, 1, 1, 0, pat(i), "R5 fill");
    for (int i = 0; i < 3; i++) cyc(0, 1, 1, 1, 0, 9'h1AA, "R3 full write");
    for (int i = 0; i < 10; i++) cyc(1, 0, 1, 1, 1, '0, "R9 read oe high");
    for (int i = 10; i < D; i++) cyc(1, 0, 1, 1, 0, '0, "R2 drain");
    for (int i = 0; i < 3; i++) cyc(1, 0, 1, 1, 0, '0, "R4 empty read");

    // Write into empty, read right after.
    do_clear("R1");
    cyc(0, 1, 1, 1, 0, 9'h055, "R13 write");
    cyc(1, 0, 1, 1, 0, '0, "R13 read");

    // Simultaneous read and write at empty, mid level and full.
    cyc(0, 0, 1, 1, 0, 9'h0F0, "R12 both at empty");
    while (m_w - m_r < D / 8) cyc(0, 1, 1, 1, 0, pat(m_w), "R12 fill");
    for (int i = 0; i < 60; i++) cyc(0, 0, 1, 1, 0, pat(m_w + 500), "R12 both mid");
    while (m_w - m_r < D) cyc(0, 1, 1, 1, 0, pat(m_w), "R12 fill");
    cyc(0, 0, 1, 1, 0, 9'h133, "R12 both at full");
    cyc(0, 0, 1, 1, 0, 9'h134, "R12 both after full");
    while (m_w - m_r > 0) cyc(1, 0, 1, 1, 0, '0, "R2 drain");

    // Rewind.
    do_clear("R1");
    for (int i = 0; i < 20; i++) cyc(0, 1, 1, 1, 0, pat(i + 77), "R10 load");
    for (int i = 0; i < 5; i++) cyc(1, 0, 1, 1, 0, '0, "R10 pre read");
    cyc(1, 1, 0, 1, 0, '0, "R10 rewind");
    for (int i = 0; i < 3; i++) cyc(1, 0, 1, 1, 0, '0, "R10 reread");

    // Commands ignored while a strobe is active.
    cyc(1, 0, 0, 1, 0, '0, "R11 rewind with read");
    cyc(1, 0, 1, 1, 0, '0, "R11 after rewind");
    cyc(0, 1, 1, 0, 0, 9'h1C3, "R11 clear with write");
    cyc(1, 0, 1, 0, 0, '0, "R11 clear with read");
    while (m_w - m_r > 0) cyc(1, 0, 1, 1, 0, '0, "R11 drain");
    cyc(1, 0, 1, 1, 0, '0, "R4 final empty");

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule